// File: doc/BRIEF.md
# Serial Configuration Write Port

This block is a slave-side serial write port that loads a small bank of 8-bit configuration registers from an external controller. The controller frames a transfer by pulling an active-low select line low. It then clocks in bits, most significant bit first. The block samples each bit on the rising edge of the serial clock.

Every transfer carries three kinds of byte, in this order:
- A device-address byte. Its upper seven bits must equal 0010000 and its lowest bit (the direction bit) must be 0.
- A pointer byte. Its top bit enables auto-increment and its low three bits pick the target register.
- Any number of data bytes.

Frames with a different address or a read request are ignored. Reading back over this port is not possible.

The serial pins are treated as asynchronous. The block brings them into the system clock domain through a synchronizer chain and detects their edges there. A controller splits into edge detection and framing on one side and a register bank on the other, and a single write strobe passes between them. The register contents are presented as one flat vector for the rest of the chip. Register 6 is reserved for status owned elsewhere and is never written. The two lowest bits of register 1 are read-only and stay 0.

Top module: `cfg_spi_wport`

## Requirements
- R1: A data bit is sampled on each rising edge of `spiClk` while `spiCsN` is low. Bits arrive MSB first, and every eight bits form one byte.
- R2: The first byte of a frame must be 8'h20 (address 0010000 in bits 7:1, direction 0 in bit 0). Any other first byte causes every later byte of that frame to be ignored until `spiCsN` returns high.
- R3: A first byte of 8'h21 (a read request) is ignored together with the rest of its frame. No register changes.
- R4: The second byte is the pointer. Bit 7 enables auto-increment, bits 2:0 select the register index, and bits 6:3 are ignored.
- R5: Each complete data byte is written to the register the pointer selects. With auto-increment set, the pointer then advances by one, wrapping from 7 to 0. Without it, the pointer stays, so the last byte wins.
- R6: Register 6 is never written and reads 8'h00.
- R7: Bits 1:0 of register 1 are read-only and stay 0. Bits 7:2 take the written data.
- R8: A data byte aimed at pointer value 7 is discarded. With auto-increment, the following byte lands in register 0.
- R9: While `rstN` is low, all registers read 8'h00.
- R10: Every falling edge of `spiCsN` restarts the bit count and byte assembly, so an aborted partial frame has no effect on the next frame.
- R11: A byte left incomplete when `spiCsN` rises is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiCsN | input | 1 | Active-low frame select from the controller |
| spiClk | input | 1 | Serial bit clock; data sampled on its rising edge |
| spiDin | input | 1 | Serial data, MSB first |
| regFlat | output | REG_COUNT*8 | Register contents; register i sits at bits i*8+7 : i*8 |

## Verification
The bench goes after pointer wrap-around across the reserved and missing indices. A design that forgot to lock register 6 or to discard pointer 7 would corrupt register 6 or lose the wrap into register 0.

It sends frames with a wrong address and with a read request. A design that only checked the address bits, or that kept decoding after a mismatch, would write data there.

It aborts a frame after five bits and ends another frame with a four-bit tail. A bit counter that does not restart would misalign the next frame, and a design that acts on partial bytes would write garbage.

It also writes all ones to register 1 and sends a pointer with bits 6:3 set. This exposes writable read-only bits and decoding of the reserved pointer bits.

// File: rtl/cfg_spi_wport_pkg.sv
package cfg_spi_wport_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 3;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA,
    ST_DROP
  } frameState_e;

  typedef struct packed {
    logic              wrEn;
    logic [PTR_W-1:0]  wrIdx;
    logic [BYTE_W-1:0] wrData;
  } wrStrobe_t;
endpackage

// File: rtl/cfg_spi_wport_ctrl.sv
module cfg_spi_wport_ctrl
  import cfg_spi_wport_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_ADDR    = 7'h10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      spiCsN,
  input  logic      spiClk,
  input  logic      spiDin,
  output wrStrobe_t strobe
);
  localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] csPipe, clkPipe, dinPipe;
  logic csS, clkS, dinS, csPrev, clkPrev;
  logic csFall, clkRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe  <= '1;
      clkPipe <= '0;
      dinPipe <= '0;
      csPrev  <= 1'b1;
      clkPrev <= 1'b0;
    end else begin
      csPipe  <= {csPipe[SYNC_STAGES-2:0], spiCsN};
      clkPipe <= {clkPipe[SYNC_STAGES-2:0], spiClk};
      dinPipe <= {dinPipe[SYNC_STAGES-2:0], spiDin};
      csPrev  <= csS;
      clkPrev <= clkS;
    end
  end

  assign csS     = csPipe[SYNC_STAGES-1];
  assign clkS    = clkPipe[SYNC_STAGES-1];
  assign dinS    = dinPipe[SYNC_STAGES-1];
  assign csFall  = !csS && csPrev;
  assign clkRise = clkS && !clkPrev;

  frameState_e       state;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] byteNow;
  logic [PTR_W-1:0]  ptr;
  logic              autoInc;
  logic              takeBit;

  assign byteNow = {shiftReg[BYTE_W-2:0], dinS};
  assign takeBit = clkRise && (state == ST_ADDR || state == ST_PTR || state == ST_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      ptr      <= '0;
      autoInc  <= 1'b0;
      strobe   <= '0;
    end else begin
      strobe.wrEn <= 1'b0;
      if (csS) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
      end else if (csFall) begin
        state    <= ST_ADDR;
        bitCnt   <= '0;
        shiftReg <= '0;
      end else if (takeBit) begin
        shiftReg <= byteNow;
        bitCnt   <= bitCnt + 1'b1;
        if (bitCnt == LAST_BIT) begin
          unique case (state)
            ST_ADDR: state <= (byteNow == ADDR_BYTE) ? ST_PTR : ST_DROP;
            ST_PTR: begin
              ptr     <= byteNow[PTR_W-1:0];
              autoInc <= byteNow[BYTE_W-1];
              state   <= ST_DATA;
            end
            ST_DATA: begin
              strobe.wrEn   <= 1'b1;
              strobe.wrIdx  <= ptr;
              strobe.wrData <= byteNow;
              if (autoInc) ptr <= ptr + 1'b1;
            end
            default: state <= ST_DROP;
          endcase
        end
      end
    end
  end

  // R1: writes only come out of the data phase of a frame
  p_write_in_frame_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (state == ST_DATA || state == ST_IDLE));
  // R2: a rejected frame produces no write
  p_drop_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DROP) |=> !strobe.wrEn);
  // R5: pointer step after a write follows the auto-increment flag
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && autoInc) |-> (ptr == PTR_W'(strobe.wrIdx + 1'b1)));
  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !autoInc) |-> (ptr == strobe.wrIdx));
  // R10: select falling edge restarts byte assembly
  p_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    csFall |=> (bitCnt == '0 && state == ST_ADDR));
endmodule

// File: rtl/cfg_spi_wport_regs.sv
module cfg_spi_wport_regs
  import cfg_spi_wport_pkg::*;
#(
  parameter int               REG_COUNT  = 7,
  parameter int               LOCKED_IDX = 6,
  parameter int               RO_REG     = 1,
  parameter logic [BYTE_W-1:0] RO_BITS   = 8'h03
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  wrStrobe_t                   strobe,
  output logic [REG_COUNT*BYTE_W-1:0] regFlat
);
  logic [BYTE_W-1:0] regQ [REG_COUNT];

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam logic [PTR_W-1:0]  IDX  = PTR_W'(i);
    localparam logic [BYTE_W-1:0] MASK = (i == RO_REG) ? ~RO_BITS : '1;
    localparam bit                WRITABLE = (i != LOCKED_IDX);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regQ[i] <= '0;
      else if (WRITABLE && strobe.wrEn && strobe.wrIdx == IDX)
        regQ[i] <= strobe.wrData & MASK;
    end

    assign regFlat[i*BYTE_W +: BYTE_W] = regQ[i];
  end

  if (LOCKED_IDX < REG_COUNT) begin : g_lock_chk
    // R6: a write aimed at the reserved index leaves it unchanged
    p_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrEn && int'(strobe.wrIdx) == LOCKED_IDX) |=> $stable(regQ[LOCKED_IDX]));
  end

  if (RO_REG < REG_COUNT) begin : g_ro_chk
    // R7: read-only bits of the mixed register never move
    p_ro_bits_r7: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> $stable(regQ[RO_REG] & RO_BITS));
  end

  // R5: registers change only when a write strobe arrives
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(regFlat));
  // R8: writes past the bank are dropped
  p_discard_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && int'(strobe.wrIdx) >= REG_COUNT) |=> $stable(regFlat));
endmodule

// File: rtl/cfg_spi_wport.sv
module cfg_spi_wport
  import cfg_spi_wport_pkg::*;
#(
  parameter int         REG_COUNT   = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h10
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        spiCsN,
  input  logic                        spiClk,
  input  logic                        spiDin,
  output logic [REG_COUNT*BYTE_W-1:0] regFlat
);
  wrStrobe_t strobe;

  cfg_spi_wport_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEV_ADDR   (DEV_ADDR)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .spiCsN(spiCsN),
    .spiClk(spiClk),
    .spiDin(spiDin),
    .strobe(strobe)
  );

  cfg_spi_wport_regs #(
    .REG_COUNT (REG_COUNT),
    .LOCKED_IDX(6),
    .RO_REG    (1),
    .RO_BITS   (8'h03)
  ) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .regFlat(regFlat)
  );
endmodule

// File: tb/cfg_spi_wport_test.sv
`timescale 1ns/1ps
module cfg_spi_wport_test;
  localparam int REGS = 7;
  localparam int HALF = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, spiCsN, spiClk, spiDin;
  logic [REGS*8-1:0] regFlat;

  cfg_spi_wport uut (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN),
    .spiClk(spiClk), .spiDin(spiDin), .regFlat(regFlat)
  );

  typedef struct {
    int         idx;
    logic [7:0] val;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  logic [7:0] model[REGS];
  int vecCount = 0;
  int missCount = 0;
  bit finished = 0;

  task automatic tick(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic shiftBits(logic [7:0] b, int n);
    for (int k = 7; k > 7 - n; k--) begin
      spiDin = b[k];
      tick(HALF);
      spiClk = 1'b1;
      tick(HALF);
      spiClk = 1'b0;
    end
  endtask

  // Expected register effect of a complete frame, taken from the requirements
  task automatic applyModel(logic [7:0] b[$]);
    logic [2:0] p;
    bit inc;
    if (b.size() < 2 || b[0] != 8'h20) return;   // R2, R3
    p   = b[1][2:0];                             // R4
    inc = b[1][7];
    for (int k = 2; k < b.size(); k++) begin
      if (p < 3'd6) model[p] = (p == 3'd1) ? (b[k] & 8'hFC) : b[k]; // R6 R7 R8
      if (inc) p = p + 3'd1;                     // R5
    end
  endtask

  task automatic pushAll(string tag);
    for (int i = 0; i < REGS; i++) begin
      expItem_t it;
      it.idx = i; it.val = model[i]; it.tag = tag;
      expQ.push_back(it);
    end
    while (expQ.size() != 0) @(posedge clk);
  endtask

  task automatic sendFrame(logic [7:0] b[$], int tailBits, logic [7:0] tail, string tag);
    spiCsN = 1'b0;
    tick(HALF);
    foreach (b[i]) shiftBits(b[i], 8);
    if (tailBits > 0) shiftBits(tail, tailBits);
    tick(HALF);
    spiCsN = 1'b1;
    tick(HALF * 3);
    applyModel(b);
    pushAll(tag);
  endtask

  // Monitor: compares one expected register per cycle away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin : mon
      expItem_t it;
      it = expQ.pop_front();
      vecCount++;
      if (regFlat[it.idx*8 +: 8] !== it.val) begin
        missCount++;
        $display("FAIL %s reg%0d actual %h expected %h", it.tag, it.idx,
                 regFlat[it.idx*8 +: 8], it.val);
      end
    end
  end

  initial begin
    tick(200000);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog expired, actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; spiCsN = 1'b1; spiClk = 1'b0; spiDin = 1'b0;
    foreach (model[i]) model[i] = 8'h00;
    tick(5);
    pushAll("R9 reset state");
    rstN = 1'b1;
    tick(4);

    sendFrame('{8'h20, 8'h00, 8'hA5}, 0, 8'h00, "R1 single write");
    sendFrame('{8'h20, 8'h82, 8'h11, 8'h22, 8'h33}, 0, 8'h00, "R5 auto-increment");
    sendFrame('{8'h20, 8'h05, 8'h44, 8'h5A}, 0, 8'h00, "R5 fixed pointer");
    sendFrame('{8'h22, 8'h00, 8'hFF}, 0, 8'h00, "R2 wrong address");
    sendFrame('{8'h21, 8'h03, 8'hEE}, 0, 8'h00, "R3 read request");
    sendFrame('{8'h20, 8'h85, 8'h66, 8'h77, 8'h88, 8'h99}, 0, 8'h00, "R8 R6 wrap past 6 and 7");
    sendFrame('{8'h20, 8'h06, 8'hC3}, 0, 8'h00, "R6 locked register");
    sendFrame('{8'h20, 8'h07, 8'hC3}, 0, 8'h00, "R8 pointer 7");
    sendFrame('{8'h20, 8'h01, 8'hFF}, 0, 8'h00, "R7 read-only bits");
    sendFrame('{8'h20, 8'h7B, 8'h3C}, 0, 8'h00, "R4 pointer bits 6:3 ignored");

    // R10: abort after five bits, then a normal frame
    spiCsN = 1'b0; tick(HALF);
    shiftBits(8'h20, 5);
    tick(HALF); spiCsN = 1'b1; tick(HALF * 3);
    sendFrame('{8'h20, 8'h04, 8'hB7}, 0, 8'h00, "R10 restart after abort");

    sendFrame('{8'h20, 8'h02, 8'h0F}, 4, 8'hF0, "R11 partial tail byte");

    // R9: reset while holding data
    rstN = 1'b0;
    tick(3);
    foreach (model[i]) model[i] = 8'h00;
    pushAll("R9 reset clears");
    rstN = 1'b1;
    tick(4);
    sendFrame('{8'h20, 8'h80, 8'h01, 8'h02}, 0, 8'h00, "R1 after reset");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule